// File: doc/BRIEF.md
# Single-Pass Streaming Run Labeller

The block takes a raster stream of colour-class codes, one pixel per clock, and gives every horizontal run of same-coloured pixels a component label in a single pass. A run is connected to the row above only through the pixel directly above each of its pixels, and only when that pixel has the same colour. Diagonal neighbours do not count. A one-row buffer holds, for each column, the colour and the final label of the row above.

Each closed run of a non-background colour produces one record on the output: label, colour, first and last column, row, and the number of distinct labels above that the run touched. A feature store downstream accumulates these records into components. Labels are never merged. When a run touches several labels, it takes the one it touches most often. The other labels are not rewritten and stay separate components. Fresh labels come from a per-frame counter. When that counter runs out, runs that would need a new label are dropped.

Top module: `run_labeller`

## Requirements
- R1: A pixel is accepted on every clock where `pix_valid` is high, with no stall. A run's record appears, with `run_valid` high for one cycle, in the cycle after the clock that captured the first pixel of a different colour. A run that ends at the row end follows R5.
- R2: A pixel links to the row above only through the pixel in the same column, and only when both have the same colour. Diagonal neighbours and pixels of another colour have no influence on the label.
- R3: Colour code 0 is background. Background runs never produce a record and hold label 0 in the row buffer.
- R4: A change of colour closes the open run. The record carries its colour, its first column `run_x0`, its last column `run_x1`, and the row index, counted from 0 at frame start.
- R5: The last pixel of a row (column IMG_W-1) always closes its run. If the previous run also closes on that clock and produces a record, the row-end record follows one cycle after it. Otherwise the row-end record appears in the cycle after the row-end pixel.
- R6: A run with no same-colour link above gets a fresh label. Fresh labels are 1, 2, 3, … within each frame, handed out in the order in which runs close.
- R7: A linked run takes the label above that it touches in the most columns. A tie goes to the numerically lowest label. `run_ncand` reports how many distinct labels were counted, and is 0 for a fresh label.
- R8: At most NCAND (4) distinct labels above are counted per run, namely the first ones met from left to right. Later distinct labels are ignored.
- R9: No merging. A label that loses the vote keeps its value wherever it was already assigned.
- R10: When no label is left (all of 1..2^LW-1 are used), a run that needs a fresh label produces no record and counts as background for the next row. `lbl_overflow` then rises and stays high until the next frame start.
- R11: `pix_sof` marks column 0 of row 0. It restarts the column, row and label counters and clears `lbl_overflow`. The first row has no neighbours above. Pixels before the first `pix_sof` are ignored.
- R12: A clock with `pix_valid` low changes nothing in the run in progress. Two such clocks in a row leave `run_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of a frame |
| pix_color | input | CW | Colour class, 0 = background |
| run_valid | output | 1 | Record valid this cycle |
| run_label | output | LW | Component label of the run |
| run_color | output | CW | Colour of the run |
| run_x0 | output | clog2(IMG_W) | First column of the run |
| run_x1 | output | clog2(IMG_W) | Last column of the run |
| run_row | output | YW | Row of the run |
| run_ncand | output | clog2(NCAND+1) | Distinct labels counted above |
| lbl_overflow | output | 1 | Labels exhausted in this frame |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of wrong design:

- **U-shaped joins and ties.** A wrong vote either keeps the first label met or breaks a tie toward the higher label.
- **Five labels above one run, where the fifth touches the most columns.** A design without the four-entry cap picks that fifth label.
- **A single-pixel run in the last column, right after another coloured run.** A design that writes one record per cycle loses one of the two records or emits it in the wrong cycle.
- **A row that exhausts the label space.** A wrong design either wraps around to label 0 or links the next row to a dropped run.
- **Diagonal touches, colour-mismatched touches, and idle cycles inside a row.** These show up as wrong links or as shifted column numbers.

// File: rtl/run_labeller.sv
module run_labeller #(
  parameter int IMG_W = 32,
  parameter int CW    = 2,
  parameter int LW    = 6,
  parameter int YW    = 10,
  parameter int NCAND = 4,
  localparam int XW   = $clog2(IMG_W),
  localparam int NCW  = $clog2(NCAND + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_valid,
  input  logic           pix_sof,
  input  logic [CW-1:0]  pix_color,
  output logic           run_valid,
  output logic [LW-1:0]  run_label,
  output logic [CW-1:0]  run_color,
  output logic [XW-1:0]  run_x0,
  output logic [XW-1:0]  run_x1,
  output logic [YW-1:0]  run_row,
  output logic [NCW-1:0] run_ncand,
  output logic           lbl_overflow
);
  localparam int KW = XW + 1;
  localparam logic [LW:0] LMAX = {1'b0, {LW{1'b1}}};

  typedef struct packed {
    logic [LW-1:0]  lbl;
    logic [CW-1:0]  clr;
    logic [XW-1:0]  x0;
    logic [XW-1:0]  x1;
    logic [YW-1:0]  y;
    logic [NCW-1:0] nc;
  } rec_t;

  function automatic logic [LW-1:0] pick(input logic [NCAND-1:0] v,
                                         input logic [NCAND-1:0][LW-1:0] l,
                                         input logic [NCAND-1:0][KW-1:0] n);
    logic [LW-1:0] bl;
    logic [KW-1:0] bn;
    logic any;
    bl = '0; bn = '0; any = 1'b0;
    for (int i = 0; i < NCAND; i++)
      if (v[i] && (!any || n[i] > bn || (n[i] == bn && l[i] < bl))) begin
        any = 1'b1; bl = l[i]; bn = n[i];
      end
    return bl;
  endfunction

  logic [CW-1:0] buf_c [IMG_W];
  logic [LW-1:0] buf_l [IMG_W];

  logic act, first_row;
  logic [XW-1:0] col;
  logic [YW-1:0] row;
  logic [CW-1:0] r_col;
  logic [XW-1:0] r_x0;
  logic [NCAND-1:0]         c_v, u_v;
  logic [NCAND-1:0][LW-1:0] c_l, u_l;
  logic [NCAND-1:0][KW-1:0] c_n, u_n;
  logic [LW:0] nl, nl_b;
  rec_t rec_a, rec_b, pend, out_r;
  logic pend_v;

  logic take, top, sol, eol, cont, link, close_a, close_b;
  logic [XW-1:0] cx, b_x0;
  logic [YW-1:0] cy;
  logic [CW-1:0] ac;
  logic [LW-1:0] al;

  assign take    = pix_valid & (pix_sof | act);
  assign cx      = pix_sof ? '0 : col;
  assign cy      = pix_sof ? '0 : row;
  assign top     = pix_sof | first_row;
  assign ac      = top ? '0 : buf_c[cx];
  assign al      = buf_l[cx];
  assign sol     = (cx == '0);
  assign eol     = (cx == XW'(IMG_W - 1));
  assign cont    = !sol && (pix_color == r_col);
  assign link    = (pix_color != '0) && (ac == pix_color);
  assign close_a = take && !cont && !sol;
  assign close_b = take && eol;
  assign b_x0    = cont ? r_x0 : cx;

  always_comb begin
    logic found;
    u_v = cont ? c_v : '0;
    u_l = cont ? c_l : '0;
    u_n = cont ? c_n : '0;
    found = 1'b0;
    if (link) begin
      for (int i = 0; i < NCAND; i++)
        if (!found && u_v[i] && u_l[i] == al) begin
          u_n[i] = u_n[i] + 1'b1;
          found = 1'b1;
        end
      for (int i = 0; i < NCAND; i++)
        if (!found && !u_v[i]) begin
          u_v[i] = 1'b1; u_l[i] = al; u_n[i] = KW'(1);
          found = 1'b1;
        end
    end
  end

  logic [NCW-1:0] nca, ncb;
  logic need_a, need_b, ok_a, ok_b, keep_a, keep_b;
  logic [LW-1:0] lab_a, lab_b;

  assign nca    = NCW'($countones(c_v));
  assign ncb    = NCW'($countones(u_v));
  assign need_a = close_a && r_col != '0 && nca == '0;
  assign ok_a   = nl <= LMAX;
  assign nl_b   = nl + {{LW{1'b0}}, need_a & ok_a};
  assign need_b = close_b && pix_color != '0 && ncb == '0;
  assign ok_b   = nl_b <= LMAX;
  assign keep_a = close_a && r_col != '0 && (nca != '0 || ok_a);
  assign keep_b = close_b && pix_color != '0 && (ncb != '0 || ok_b);
  assign lab_a  = !keep_a ? '0 : (nca != '0) ? pick(c_v, c_l, c_n) : nl[LW-1:0];
  assign lab_b  = !keep_b ? '0 : (ncb != '0) ? pick(u_v, u_l, u_n) : nl_b[LW-1:0];

  assign rec_a = '{lbl: lab_a, clr: r_col, x0: r_x0, x1: cx - 1'b1, y: cy, nc: nca};
  assign rec_b = '{lbl: lab_b, clr: pix_color, x0: b_x0, x1: cx, y: cy, nc: ncb};

  always_ff @(posedge clk)
    for (int i = 0; i < IMG_W; i++) begin
      if (close_a && XW'(i) >= r_x0 && XW'(i) < cx) begin
        buf_c[i] <= keep_a ? r_col : '0;
        buf_l[i] <= lab_a;
      end
      if (close_b && XW'(i) >= b_x0) begin
        buf_c[i] <= keep_b ? pix_color : '0;
        buf_l[i] <= lab_b;
      end
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; first_row <= 1'b0; col <= '0; row <= '0;
      r_col <= '0; r_x0 <= '0; c_v <= '0; c_l <= '0; c_n <= '0;
      nl <= (LW+1)'(1); lbl_overflow <= 1'b0;
      run_valid <= 1'b0; out_r <= '0; pend <= '0; pend_v <= 1'b0;
    end else begin
      if (take) begin
        act       <= 1'b1;
        col       <= eol ? '0 : cx + 1'b1;
        row       <= eol ? cy + 1'b1 : cy;
        first_row <= top && !eol;
        r_col     <= pix_color;
        r_x0      <= b_x0;
        c_v <= u_v; c_l <= u_l; c_n <= u_n;
        nl  <= pix_sof ? (LW+1)'(1) : nl_b + {{LW{1'b0}}, need_b & ok_b};
        lbl_overflow <= !pix_sof &&
                        (lbl_overflow | (need_a & !ok_a) | (need_b & !ok_b));
      end
      if (pend_v) begin
        run_valid <= 1'b1; out_r <= pend; pend_v <= 1'b0;
      end else if (keep_a) begin
        run_valid <= 1'b1; out_r <= rec_a; pend <= rec_b; pend_v <= keep_b;
      end else if (keep_b) begin
        run_valid <= 1'b1; out_r <= rec_b;
      end else begin
        run_valid <= 1'b0;
      end
    end
  end

  assign run_label = out_r.lbl;
  assign run_color = out_r.clr;
  assign run_x0    = out_r.x0;
  assign run_x1    = out_r.x1;
  assign run_row   = out_r.y;
  assign run_ncand = out_r.nc;
endmodule

module run_labeller_chk #(
  parameter int CW    = 2,
  parameter int LW    = 6,
  parameter int XW    = 5,
  parameter int NCW   = 3,
  parameter int NCAND = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_valid,
  input logic           pix_sof,
  input logic           run_valid,
  input logic [LW-1:0]  run_label,
  input logic [CW-1:0]  run_color,
  input logic [XW-1:0]  run_x0,
  input logic [XW-1:0]  run_x1,
  input logic [NCW-1:0] run_ncand,
  input logic           lbl_overflow
);
  assert_bg_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_color != '0);
  assert_label_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_label != '0);
  assert_span_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_x0 <= run_x1);
  assert_cand_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> run_ncand <= NCW'(NCAND));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_overflow && !(pix_valid && pix_sof) |=> lbl_overflow);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pix_valid) && !$past(pix_valid, 2) |-> !run_valid);
endmodule

bind run_labeller run_labeller_chk #(.CW(CW), .LW(LW), .XW(XW), .NCW(NCW), .NCAND(NCAND)) u_chk (.*);

// File: tb/run_labeller_tb.sv
`timescale 1ns/1ps
module run_labeller_tb;
  localparam int W = 32;
  localparam int NC = 4;
  localparam int LTOP = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 1'b0, pix_sof = 1'b0;
  logic [1:0] pix_color = '0;
  logic run_valid, lbl_overflow;
  logic [5:0] run_label;
  logic [1:0] run_color;
  logic [4:0] run_x0, run_x1;
  logic [9:0] run_row;
  logic [2:0] run_ncand;

  run_labeller u_dut (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_color(pix_color), .run_valid(run_valid), .run_label(run_label), .run_color(run_color),
    .run_x0(run_x0), .run_x1(run_x1), .run_row(run_row), .run_ncand(run_ncand),
    .lbl_overflow(lbl_overflow));

  always #2 clk = ~clk;

  typedef struct {int lbl; int clr; int x0; int x1; int row; int nc; int t;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  int pix[W], tc[W], prev_c[W], prev_l[W];
  int nl, rowi;
  bit ovf;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string what, input int a, input int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, a, e);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit now;
    now = q.size() > 0 && q[0].t == cyc;
    chk("R1 record timing (run_valid)", int'(run_valid), int'(now));
    if (now) begin
      exp_t e;
      e = q.pop_front();
      if (run_valid) begin
        chk("R6/R7 label", run_label, e.lbl);
        chk("R4 colour", run_color, e.clr);
        chk("R4 first column", run_x0, e.x0);
        chk("R4 last column", run_x1, e.x1);
        chk("R4 row", run_row, e.row);
        chk("R7/R8 candidate count", run_ncand, e.nc);
      end
    end
  end

  task automatic model_row(input bit sof);
    int s, e, c, lbl, t, lastt, best, bn;
    bit kept;
    int cl[$];
    int cn[$];
    int nwc[W];
    int nwl[W];
    if (sof) begin nl = 1; ovf = 0; rowi = 0; end
    lastt = -1;
    s = 0;
    while (s < W) begin
      c = pix[s]; e = s;
      while (e + 1 < W && pix[e+1] == c) e++;
      lbl = 0; kept = 0; cl.delete(); cn.delete();
      if (c != 0) begin
        for (int x = s; x <= e; x++)
          if (!sof && prev_c[x] == c) begin
            int k;
            k = -1;
            foreach (cl[j]) if (cl[j] == prev_l[x]) k = j;
            if (k >= 0) cn[k]++;
            else if (cl.size() < NC) begin cl.push_back(prev_l[x]); cn.push_back(1); end
          end
        if (cl.size() > 0) begin
          best = cl[0]; bn = cn[0];
          foreach (cl[j]) if (cn[j] > bn || (cn[j] == bn && cl[j] < best)) begin
            best = cl[j]; bn = cn[j];
          end
          lbl = best; kept = 1;
        end else if (nl <= LTOP) begin
          lbl = nl; nl++; kept = 1;
        end else ovf = 1;
        if (kept) begin
          if (e < W - 1) t = tc[e+1];
          else t = (lastt == tc[W-1]) ? tc[W-1] + 1 : tc[W-1];
          q.push_back('{lbl, c, s, e, rowi, cl.size(), t});
          lastt = t;
        end
      end
      for (int x = s; x <= e; x++) begin nwc[x] = kept ? c : 0; nwl[x] = lbl; end
      s = e + 1;
    end
    for (int x = 0; x < W; x++) begin prev_c[x] = nwc[x]; prev_l[x] = nwl[x]; end
    rowi++;
  endtask

  task automatic drive_row(input bit sof, input int gap);
    int t;
    @(negedge clk);
    t = cyc + 1;
    for (int x = 0; x < W; x++) begin
      if (x == gap) t++;
      tc[x] = t; t++;
    end
    model_row(sof);
    for (int x = 0; x < W; x++) begin
      if (x == gap) begin pix_valid = 1'b0; @(negedge clk); end
      pix_valid = 1'b1; pix_sof = sof && x == 0; pix_color = 2'(pix[x]);
      @(negedge clk);
    end
    pix_valid = 1'b0; pix_sof = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    for (int x = 0; x < W; x++) pix[x] = 0;
  endtask

  task automatic put(input int a, input int b, input int c);
    for (int x = a; x <= b; x++) pix[x] = c;
  endtask

  task automatic rand_row();
    int x, len, c;
    x = 0;
    while (x < W) begin
      len = 1 + $urandom_range(7);
      c = ($urandom_range(1) == 0) ? 0 : $urandom_range(3, 1);
      for (int k = 0; k < len && x < W; k++) begin pix[x] = c; x++; end
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset run_valid", int'(run_valid), 0);
    chk("R10 reset overflow", int'(lbl_overflow), 0);

    // R11: pixels before the first frame start are ignored
    pix_valid = 1'b1; pix_color = 2'd1; idle(5); pix_valid = 1'b0; idle(2);

    // Frame 1 - R4 R6 R11: rectangles, run reaching the row end
    for (int y = 0; y < 5; y++) begin
      clr();
      if (y < 4) put(4, 9, 1);
      if (y == 1 || y == 2) put(20, 25, 2);
      if (y == 0) put(28, 31, 3);
      drive_row(y == 0, y == 2 ? 7 : -1);   // R12 idle gap inside a row
    end

    // Frame 2 - R7 R9 R2: U join, tie, diagonal and colour mismatch
    for (int y = 0; y < 7; y++) begin
      clr();
      if (y < 3) begin put(2, 4, 1); put(10, 15, 1); end
      if (y == 3) put(2, 15, 1);
      if (y == 4) put(10, 12, 1);
      if (y == 0) begin put(20, 21, 1); put(24, 25, 1); end
      if (y == 1) put(20, 25, 1);
      if (y == 4) put(17, 17, 2);
      if (y == 5) begin put(18, 18, 2); put(10, 12, 3); end
      drive_row(y == 0, -1);
    end

    // Frame 3 - R8 R5: five labels above, row-end single pixels
    for (int y = 0; y < 4; y++) begin
      clr();
      if (y == 0) begin put(0, 0, 1); put(2, 2, 1); put(4, 4, 1); put(6, 6, 1); put(8, 15, 1); end
      if (y == 1) put(0, 15, 1);
      if (y == 2) begin put(0, 30, 2); put(31, 31, 3); end
      if (y == 3) put(31, 31, 1);
      drive_row(y == 0, -1);
    end

    // Frame 4 - R10: label exhaustion
    for (int y = 0; y < 9; y++) begin
      clr();
      if (y % 2 == 0 && y < 8) for (int x = 0; x < W; x += 2) pix[x] = 1;
      if (y == 7) put(28, 30, 1);
      drive_row(y == 0, -1);
    end
    idle(3);
    chk("R10 overflow flag raised", int'(lbl_overflow), int'(ovf));

    // Frame 5 - R11: frame start clears overflow and restarts labels
    clr(); put(3, 5, 2);
    drive_row(1, -1);
    chk("R11 overflow cleared at frame start", int'(lbl_overflow), 0);
    clr(); put(4, 6, 2); put(12, 13, 1);
    drive_row(0, -1);

    // Random frames - all requirements against the model
    for (int f = 0; f < 6; f++) begin
      for (int y = 0; y < 16; y++) begin
        rand_row();
        drive_row(y == 0, ($urandom_range(3) == 0) ? $urandom_range(W - 1, 1) : -1);
      end
      idle(3);
      chk("R10 overflow flag after random frame", int'(lbl_overflow), int'(ovf));
    end

    idle(4);
    chk("R1 no records left over", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule